// File: doc/BRIEF.md
# Puncture Rate and Phase Search Controller

This block finds the code rate and the puncture phase that a punctured convolutional decoder needs before its output means anything. The decoder reports, one bit period at a time, whether the decoded bit disagreed with the re-encoded stream. The block counts those error indications over fixed windows of bit periods. It compares each window's count with a threshold held for the rate under test. It steers a rate index and a phase index back to the depuncturer until a window passes. After that it raises a lock flag and keeps the setting through short bursts of errors.

Five rate slots exist, indexed 0 to 4 as 1/2, 2/3, 3/4, 5/6, and either 7/8 or 6/7 in slot 4. A host picks which slots may be visited, sets one 7-bit threshold per slot, sets a hysteresis depth, and chooses between three search styles. The automatic style walks every phase of every enabled rate. The frozen style keeps the rate and cycles only the phase. In the manual style the host places the rate and steps the phase with a control bit. The last window's error count is always readable.

Top module: `punct_rate_search`

## Requirements
- R1: After each WIN_BITS-th accepted bit period (`bit_valid` high) since the window began, `err_rate` takes the number of error indications in that window on the next clock, saturating at 255, and holds it until the next window completes.
- R2: A window fails when its error count is strictly greater than the 7-bit threshold of the current rate, taken from `rate_thr[7*r+6:7*r]` for rate index r; a count equal to the threshold passes.
- R3: In automatic mode (`search_manual`=0, `search_freeze`=0) a failing window while unlocked moves to the next phase; after the last phase of a rate it moves to the next enabled rate index in ascending cyclic order, skipping disabled ones (bit r of `rate_en` enables rate r), and the phase restarts at 0 on every rate change. If the current rate is disabled, the next enabled rate is selected on the next clock.
- R4: The phase count per rate index 0..4 is 1, 2, 3, 5, and 7 for slot 4, or 6 when `alt_rate_set`=1. `phase_idx` never reaches 7.
- R5: The first passing window sets `locked` on the following clock; a failure that exhausts the hysteresis clears it.
- R6: While locked, `locked` drops and the search resumes only after `hyst_len` consecutive failing windows, with `hyst_len`=0 treated as 1; any passing window clears the run.
- R7: In frozen mode (`search_manual`=0, `search_freeze`=1) a failing window advances only the phase, wrapping to 0 within the current rate, and the rate index never changes.
- R8: In manual mode (`search_manual`=1) the lowest enabled rate is forced with phase 0 on change, `locked` is high, window results are ignored, and each 0-to-1 transition of `search_freeze` advances the phase by one with wrap.
- R9: With `rate_en` all zero, `locked` is low on the next clock and the rate and phase indexes hold.
- R10: Whenever the rate or phase index changes, the partly filled window is discarded, together with the bit sampled on that clock, and a new window starts.
- R11: Synchronous reset (`rst_n` low) gives rate 0, phase 0, `locked` low and `err_rate` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_valid | input | 1 | One decoded bit period on this clock |
| bit_err | input | 1 | Error indication for that bit period |
| rate_en | input | 5 | Enable mask, bit r for rate index r |
| rate_thr | input | 35 | Five 7-bit thresholds, rate r at bits 7r+6..7r |
| hyst_len | input | 3 | Consecutive failing windows needed to lose lock |
| search_manual | input | 1 | Manual mode select |
| search_freeze | input | 1 | Frozen-rate select; phase step strobe in manual mode |
| alt_rate_set | input | 1 | Slot 4 is 6/7 (6 phases) instead of 7/8 (7 phases) |
| rate_idx | output | 3 | Selected rate index |
| phase_idx | output | 3 | Selected puncture phase |
| locked | output | 1 | Search has settled |
| err_rate | output | 8 | Error count of the last completed window |

## Verification
The bench targets the boundary between a count equal to the threshold and one above it. An off-by-one compare would lock on a marginal channel or never lock. It closes the loop with a channel whose error density depends on whether the block sits on the true rate and phase. A wrong phase count, a wrong wrap or a failure to skip a disabled rate then shows as a search that settles on the wrong setting or runs past it. Error bursts shorter and longer than the hysteresis depth separate a design that drops lock on the first bad window from one that never drops it. Manual stepping, the all-ones window that saturates the readout, and the empty mask are each compared cycle by cycle against a behavioural model. That model also tracks the window restart on every retune, so a design that keeps stale counts fails the readout comparison.

// File: rtl/rps_pkg.sv
// Shared constants and the per-rate phase table for the puncture search.
// Assumes five rate slots; slot 4 carries either the 7/8 or the 6/7 pattern.
package rps_pkg;
    localparam int NUM_RATES = 5;
    localparam int RATE_W    = 3;
    localparam int PHASE_W   = 3;
    localparam int THR_W     = 7;

    // Number of puncture phases (pattern length) for rate slot r.
    function automatic logic [PHASE_W-1:0] phases_of(input logic [RATE_W-1:0] r,
                                                     input logic alt);
        logic [PHASE_W-1:0] n;
        case (r)
            3'd0:    n = 3'd1;
            3'd1:    n = 3'd2;
            3'd2:    n = 3'd3;
            3'd3:    n = 3'd5;
            3'd4:    n = alt ? 3'd6 : 3'd7;
            default: n = 3'd1;
        endcase
        return n;
    endfunction
endpackage

// File: rtl/rps_err_window.sv
// Counts error indications over windows of WIN_BITS accepted bit periods.
// Raises win_done for one clock with the raw count, and keeps a saturated
// readout of the last window. A restart discards the partial window and the
// bit offered on the same clock.
module rps_err_window #(
    parameter int WIN_BITS = 256,
    parameter int RD_W     = 8,
    localparam int CNT_W   = $clog2(WIN_BITS + 1),
    localparam int POS_W   = (WIN_BITS > 1) ? $clog2(WIN_BITS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_valid,
    input  logic             bit_err,
    input  logic             restart,
    output logic             win_done,
    output logic [CNT_W-1:0] win_errs,
    output logic [RD_W-1:0]  err_rate
);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(WIN_BITS - 1);
    localparam int               RD_MAX   = (1 << RD_W) - 1;

    logic [POS_W-1:0] pos_q;
    logic [CNT_W-1:0] acc_q;
    logic [CNT_W:0]   total;
    logic             closing;

    // Count of the window including the bit offered on this clock.
    always_comb begin
        total   = {1'b0, acc_q} + (CNT_W + 1)'(bit_err);
        closing = bit_valid && !restart && (pos_q == LAST_POS);
    end

    // Window position, accumulator and per-window results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q    <= '0;
            acc_q    <= '0;
            win_done <= 1'b0;
            win_errs <= '0;
            err_rate <= '0;
        end else begin
            win_done <= 1'b0;
            if (restart) begin
                pos_q <= '0;
                acc_q <= '0;
            end else if (bit_valid) begin
                if (pos_q == LAST_POS) begin
                    win_done <= 1'b1;
                    win_errs <= CNT_W'(total);
                    err_rate <= (32'(total) > RD_MAX) ? RD_W'(RD_MAX) : RD_W'(total);
                    pos_q    <= '0;
                    acc_q    <= '0;
                end else begin
                    pos_q <= pos_q + 1'b1;
                    acc_q <= CNT_W'(total);
                end
            end
        end
    end

    AST_READOUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !closing |=> $stable(err_rate)); // R1
    AST_DONE_AFTER_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |-> $past(closing)); // R1
endmodule

// File: rtl/rps_rate_step.sv
// Combinational stepping helpers: phase wrap, next enabled rate in cyclic
// order, lowest enabled rate, and whether the current rate is enabled.
// Assumes rate_q is below NUM_RATES; an out-of-range value reads as disabled.
module rps_rate_step
    import rps_pkg::*;
(
    input  logic [RATE_W-1:0]    rate_q,
    input  logic [PHASE_W-1:0]   phase_q,
    input  logic [NUM_RATES-1:0] rate_en,
    input  logic                 alt,
    output logic [PHASE_W-1:0]   phase_wrap,
    output logic                 phase_last,
    output logic [RATE_W-1:0]    rate_next,
    output logic [RATE_W-1:0]    rate_low,
    output logic                 rate_ok
);
    logic [PHASE_W-1:0] nph;

    // Phase stepping within the current rate's pattern.
    always_comb begin
        nph        = phases_of(rate_q, alt);
        phase_last = ({1'b0, phase_q} + 4'd1) >= {1'b0, nph};
        phase_wrap = phase_last ? '0 : phase_q + 1'b1;
    end

    // Next enabled rate after the current one, wrapping; itself if alone.
    always_comb begin
        logic found;
        found     = 1'b0;
        rate_next = rate_q;
        for (int k = 1; k <= NUM_RATES; k++) begin
            int idx;
            idx = (int'(rate_q) + k) % NUM_RATES;
            if (!found && rate_en[idx]) begin
                found     = 1'b1;
                rate_next = RATE_W'(idx);
            end
        end
    end

    // Lowest enabled rate and enable bit of the current rate.
    always_comb begin
        rate_low = '0;
        rate_ok  = 1'b0;
        for (int i = NUM_RATES - 1; i >= 0; i--) begin
            if (rate_en[i]) rate_low = RATE_W'(i);
            if (rate_q == RATE_W'(i)) rate_ok = rate_en[i];
        end
    end
endmodule

// File: rtl/rps_search.sv
// Search state machine: holds rate, phase, lock and the hysteresis run.
// Acts on window results in automatic and frozen modes, follows the host in
// manual mode, and flags a retune whenever rate or phase will change.
module rps_search
    import rps_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       win_done,
    input  logic [CNT_W-1:0]           win_errs,
    input  logic [NUM_RATES-1:0]       rate_en,
    input  logic [NUM_RATES*THR_W-1:0] rate_thr,
    input  logic [2:0]                 hyst_len,
    input  logic                       manual,
    input  logic                       freeze,
    input  logic                       alt,
    output logic [RATE_W-1:0]          rate_q,
    output logic [PHASE_W-1:0]         phase_q,
    output logic                       locked_q,
    output logic                       retune
);
    logic [THR_W-1:0]   thr_arr [NUM_RATES];
    logic [THR_W-1:0]   cur_thr;
    logic [2:0]         hcnt_q, hcnt_d;
    logic               frz_q;
    logic [RATE_W-1:0]  rate_d, rate_next, rate_low;
    logic [PHASE_W-1:0] phase_d, phase_wrap;
    logic               lock_d, phase_last, rate_ok, fail;

    // Unpack the per-rate thresholds.
    for (genvar g = 0; g < NUM_RATES; g++) begin : g_thr
        assign thr_arr[g] = rate_thr[g*THR_W +: THR_W];
    end

    // Threshold of the rate under test.
    always_comb begin
        cur_thr = '0;
        for (int i = 0; i < NUM_RATES; i++)
            if (rate_q == RATE_W'(i)) cur_thr = thr_arr[i];
    end

    rps_rate_step u_step (
        .rate_q     (rate_q),
        .phase_q    (phase_q),
        .rate_en    (rate_en),
        .alt        (alt),
        .phase_wrap (phase_wrap),
        .phase_last (phase_last),
        .rate_next  (rate_next),
        .rate_low   (rate_low),
        .rate_ok    (rate_ok)
    );

    // Next rate, phase, lock and hysteresis run.
    always_comb begin
        rate_d  = rate_q;
        phase_d = phase_q;
        lock_d  = locked_q;
        hcnt_d  = hcnt_q;
        fail    = 32'(win_errs) > 32'(cur_thr);
        if (rate_en == '0) begin
            lock_d = 1'b0;
            hcnt_d = '0;
        end else if (manual) begin
            lock_d = 1'b1;
            hcnt_d = '0;
            if (rate_q != rate_low) begin
                rate_d  = rate_low;
                phase_d = '0;
            end else if (freeze && !frz_q) begin
                phase_d = phase_wrap;
            end
        end else if (!freeze && !rate_ok) begin
            rate_d  = rate_next;
            phase_d = '0;
            lock_d  = 1'b0;
            hcnt_d  = '0;
        end else if (win_done) begin
            if (!fail) begin
                lock_d = 1'b1;
                hcnt_d = '0;
            end else if (locked_q && ({1'b0, hcnt_q} + 4'd1 < {1'b0, hyst_len})) begin
                hcnt_d = hcnt_q + 1'b1;
            end else begin
                lock_d = 1'b0;
                hcnt_d = '0;
                if (freeze) begin
                    phase_d = phase_wrap;
                end else if (!phase_last) begin
                    phase_d = phase_wrap;
                end else begin
                    rate_d  = rate_next;
                    phase_d = '0;
                end
            end
        end
        retune = (rate_d != rate_q) || (phase_d != phase_q);
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_q   <= '0;
            phase_q  <= '0;
            locked_q <= 1'b0;
            hcnt_q   <= '0;
            frz_q    <= 1'b0;
        end else begin
            rate_q   <= rate_d;
            phase_q  <= phase_d;
            locked_q <= lock_d;
            hcnt_q   <= hcnt_d;
            frz_q    <= freeze;
        end
    end

    AST_EMPTY_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_en == '0) |=> !locked_q); // R9
    AST_MANUAL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (manual && rate_en != '0) |=> locked_q); // R8
    AST_RATE_CHANGE_PHASE0: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_q != $past(rate_q)) |-> (phase_q == '0)); // R3
    AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q != 3'd7); // R4
    AST_LOCK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked_q) |-> ($past(win_done) || $past(manual))); // R5
endmodule

// File: rtl/punct_rate_search.sv
// Top of the puncture rate and phase search: an error-window counter feeding
// the search state machine. The retune flag restarts the window so that each
// decision rests on bits decoded with a single setting.
module punct_rate_search
    import rps_pkg::*;
#(
    parameter int WIN_BITS = 256
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bit_valid,
    input  logic                       bit_err,
    input  logic [NUM_RATES-1:0]       rate_en,
    input  logic [NUM_RATES*THR_W-1:0] rate_thr,
    input  logic [2:0]                 hyst_len,
    input  logic                       search_manual,
    input  logic                       search_freeze,
    input  logic                       alt_rate_set,
    output logic [RATE_W-1:0]          rate_idx,
    output logic [PHASE_W-1:0]         phase_idx,
    output logic                       locked,
    output logic [7:0]                 err_rate
);
    localparam int CNT_W = $clog2(WIN_BITS + 1);

    logic             win_done, retune;
    logic [CNT_W-1:0] win_errs;

    rps_err_window #(.WIN_BITS(WIN_BITS), .RD_W(8)) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_valid (bit_valid),
        .bit_err   (bit_err),
        .restart   (retune),
        .win_done  (win_done),
        .win_errs  (win_errs),
        .err_rate  (err_rate)
    );

    rps_search #(.CNT_W(CNT_W)) u_srch (
        .clk      (clk),
        .rst_n    (rst_n),
        .win_done (win_done),
        .win_errs (win_errs),
        .rate_en  (rate_en),
        .rate_thr (rate_thr),
        .hyst_len (hyst_len),
        .manual   (search_manual),
        .freeze   (search_freeze),
        .alt      (alt_rate_set),
        .rate_q   (rate_idx),
        .phase_q  (phase_idx),
        .locked_q (locked),
        .retune   (retune)
    );
endmodule

// File: tb/punct_rate_search_test.sv
// Closed-loop bench: a channel whose error density depends on whether the
// design sits on the true rate and phase, a behavioural model compared on
// every clock, and directed checks per requirement.
module punct_rate_search_test;
    localparam int CLK_PERIOD = 10;
    localparam int WIN        = 256;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_valid = 1'b0, bit_err = 1'b0;
    logic [4:0]  rate_en = 5'b11111;
    logic [34:0] rate_thr;
    logic [2:0]  hyst_len = 3'd2;
    logic        search_manual = 1'b0, search_freeze = 1'b0, alt_rate_set = 1'b0;
    logic [2:0]  rate_idx, phase_idx;
    logic        locked;
    logic [7:0]  err_rate;

    int thr [5];
    int errors = 0, checks = 0, cyc = 0;
    // channel: 0 = closed loop random, 1 = fixed K errors per 256 cycles
    int ch_mode = 0, k_err = 0, true_rate = 0, true_phase = 0;
    int lo_dens = 2, hi_dens = 120;
    bit rand_valid = 1'b1;

    // model state
    int m_rate, m_phase, m_h, m_pos, m_acc, m_errs, m_er;
    bit m_lock, m_frz, m_done;

    punct_rate_search uut (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_err(bit_err),
        .rate_en(rate_en), .rate_thr(rate_thr), .hyst_len(hyst_len),
        .search_manual(search_manual), .search_freeze(search_freeze),
        .alt_rate_set(alt_rate_set), .rate_idx(rate_idx), .phase_idx(phase_idx),
        .locked(locked), .err_rate(err_rate)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb for (int i = 0; i < 5; i++) rate_thr[i*7 +: 7] = 7'(thr[i]);

    function automatic int nph(int r, bit alt);
        case (r)
            0: return 1; 1: return 2; 2: return 3; 3: return 5;
            default: return alt ? 6 : 7;
        endcase
    endfunction

    function automatic int next_en(int r, logic [4:0] en);
        for (int k = 1; k <= 5; k++) if (en[(r + k) % 5]) return (r + k) % 5;
        return r;
    endfunction

    function automatic int low_en(logic [4:0] en);
        for (int i = 0; i < 5; i++) if (en[i]) return i;
        return 0;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Behavioural reference model, advanced on every rising edge.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_rate = 0; m_phase = 0; m_lock = 0; m_h = 0; m_frz = 0;
            m_pos = 0; m_acc = 0; m_done = 0; m_errs = 0; m_er = 0;
        end else begin
            int nr, np, nh, n;
            bit nl, rt;
            nr = m_rate; np = m_phase; nl = m_lock; nh = m_h;
            n = nph(m_rate, alt_rate_set);
            if (rate_en == 0) begin
                nl = 0; nh = 0;
            end else if (search_manual) begin
                nl = 1; nh = 0;
                if (m_rate != low_en(rate_en)) begin nr = low_en(rate_en); np = 0; end
                else if (search_freeze && !m_frz) np = (m_phase + 1 >= n) ? 0 : m_phase + 1;
            end else if (!search_freeze && !rate_en[m_rate]) begin
                nr = next_en(m_rate, rate_en); np = 0; nl = 0; nh = 0;
            end else if (m_done) begin
                if (m_errs <= thr[m_rate]) begin nl = 1; nh = 0; end
                else if (m_lock && (m_h + 1 < int'(hyst_len))) nh = m_h + 1;
                else begin
                    nl = 0; nh = 0;
                    if (search_freeze || m_phase + 1 < n) np = (m_phase + 1 >= n) ? 0 : m_phase + 1;
                    else begin nr = next_en(m_rate, rate_en); np = 0; end
                end
            end
            rt = (nr != m_rate) || (np != m_phase);
            m_done = 0;
            if (rt) begin m_pos = 0; m_acc = 0; end
            else if (bit_valid) begin
                if (m_pos == WIN - 1) begin
                    m_done = 1; m_errs = m_acc + int'(bit_err);
                    m_er = (m_errs > 255) ? 255 : m_errs;
                    m_pos = 0; m_acc = 0;
                end else begin
                    m_pos++; m_acc += int'(bit_err);
                end
            end
            m_rate = nr; m_phase = np; m_lock = nl; m_h = nh; m_frz = search_freeze;
        end
    end

    // Compare with the model and drive the channel, away from the edge.
    always @(negedge clk) begin
        if (rst_n) begin
            check(rate_idx == 3'(m_rate), "R3 rate_idx", rate_idx, m_rate);
            check(phase_idx == 3'(m_phase), "R4 phase_idx", phase_idx, m_phase);
            check(locked == m_lock, "R5 locked", locked, m_lock);
            check(err_rate == 8'(m_er), "R10 err_rate", err_rate, m_er);
        end
        if (ch_mode == 1) begin
            bit_valid = 1'b1;
            bit_err   = (cyc % WIN) < k_err;
        end else begin
            bit_valid = rand_valid ? 1'b1 : ($urandom_range(3) != 0);
            bit_err   = $urandom_range(255) <
                        ((m_rate == true_rate && m_phase == true_phase) ? lo_dens : hi_dens);
        end
        if (cyc > WATCHDOG) begin
            check(1'b0, "watchdog", cyc, WATCHDOG);
            finish_run();
        end
    end

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_windows(int n);
        repeat (n * WIN + 4) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 5; i++) thr[i] = 20;
        do_reset();
        // R11: reset state
        check(rate_idx == 0 && phase_idx == 0, "R11 reset indexes", {rate_idx, phase_idx}, 0);
        check(!locked && err_rate == 0, "R11 reset lock/readout", {locked, err_rate}, 0);

        // R3: automatic search to rate 3 phase 4 with gapped input
        true_rate = 3; true_phase = 4; rand_valid = 1'b0;
        wait_windows(34);
        check(locked == 1, "R5 lock reached", locked, 1);
        check(rate_idx == 3 && phase_idx == 4, "R3 search target", {rate_idx, phase_idx}, {3'd3, 3'd4});

        // R6: short burst under hysteresis 3 keeps lock, long burst drops it
        hyst_len = 3'd3; rand_valid = 1'b1;
        wait_windows(1);
        ch_mode = 1; k_err = 255;
        repeat (200) @(negedge clk);
        ch_mode = 0;
        wait_windows(2);
        check(locked == 1, "R6 burst tolerated", locked, 1);
        ch_mode = 1; k_err = 255;
        wait_windows(4);
        ch_mode = 0;
        check(!(rate_idx == 3 && phase_idx == 4 && locked), "R6 lock lost", locked, 0);

        // R4: disabled slots skipped, slot 4 with six phases
        do_reset();
        rate_en = 5'b10110; alt_rate_set = 1'b1; true_rate = 4; true_phase = 5;
        hyst_len = 3'd2;
        wait_windows(14);
        check(rate_idx == 4 && phase_idx == 5 && locked, "R4 slot 4 alt phase",
              {rate_idx, phase_idx}, {3'd4, 3'd5});

        // R2: count equal to threshold passes, one above fails
        do_reset();
        rate_en = 5'b00010; thr[1] = 30; ch_mode = 1; k_err = 30; hyst_len = 3'd0;
        wait_windows(3);
        check(locked == 1 && rate_idx == 1, "R2 equal passes", locked, 1);
        check(err_rate == 30, "R1 readout count", err_rate, 30);
        k_err = 31;
        wait_windows(3);
        check(locked == 0, "R2 above fails", locked, 0);

        // R1: saturation of the readout
        k_err = 256;
        wait_windows(2);
        check(err_rate == 255, "R1 saturation", err_rate, 255);

        // R7: frozen mode keeps rate 3 while phases wrap
        do_reset();
        rate_en = 5'b01000; k_err = 100; thr[3] = 20;
        repeat (5) @(negedge clk);
        search_freeze = 1'b1; rate_en = 5'b11111;
        wait_windows(8);
        check(rate_idx == 3, "R7 rate frozen", rate_idx, 3);
        search_freeze = 1'b0;

        // R8: manual forcing and phase stepping
        do_reset();
        search_manual = 1'b1; rate_en = 5'b00100; k_err = 200;
        repeat (4) @(negedge clk);
        for (int s = 0; s < 4; s++) begin
            search_freeze = 1'b1; repeat (2) @(negedge clk);
            search_freeze = 1'b0; repeat (2) @(negedge clk);
        end
        wait_windows(1);
        check(rate_idx == 2 && phase_idx == 1 && locked, "R8 manual step",
              {rate_idx, phase_idx}, {3'd2, 3'd1});
        search_manual = 1'b0;

        // R9: empty mask idles unlocked with indexes held
        rate_en = 5'b00000;
        wait_windows(2);
        check(locked == 0, "R9 idle unlocked", locked, 0);
        check(rate_idx == 2 && phase_idx == 1, "R9 indexes held", {rate_idx, phase_idx}, {3'd2, 3'd1});

        finish_run();
    end
endmodule